// File: doc/BRIEF.md
# Saturating 48-bit accumulator bank

This block keeps a small bank of 48-bit multiply-accumulate registers, each paired with a sticky per-register overflow flag. Each cycle a three-bit command selects one operation. It can add a 64-bit product to one register or subtract the product from it. It can load a register from a 32-bit operand, copy one register into another, or clear one register's flag. After an add or subtract, the result is tested for overflow according to the arithmetic mode. When the saturation enable is high, an overflowing result is clamped to a mode-dependent limit. When it is low, the result wraps.

The product arrives already formed by an external multiplier. The register contents are visible at all times on a flattened output bus, with register 0 in the low 48 bits. Readout rounding and any shaping of the product happen outside this block.

Top module: `mac_acc_bank`

## Requirements
- R1: After reset, all accumulators are zero, all per-accumulator flags `pav` are 0, and `ovf` is 0.
- R2: Command 1 (add) writes `acc[dst] + product` into `acc[dst]` when no overflow occurs. For the add, `acc[dst]` is first extended to 64 bits: zero-extended in mode 1, sign-extended otherwise.
- R3: Command 2 (subtract) writes `acc[dst] - product`, with the same extension as R2, when no overflow occurs.
- R4: In mode 0 (signed integer), the result overflows when the 64-bit sum is not equal to its own low 48 bits sign-extended. With `sat_en` high, an overflowing result becomes 0x0000_7FFF_FFFF for a non-negative sum and 0xFFFF_8000_0000 for a negative sum. The sign is taken from bit 63.
- R5: In modes 0 and 2 with `sat_en` low, an overflowing result wraps: the low 48 bits of the sum are stored.
- R6: In mode 1 (unsigned), the result overflows when any sum bit at position 48 or above is set. With `sat_en` high, a sum greater than 2^53 is stored as 0, and any other overflowing sum is stored as 2^48-1.
- R7: In mode 1 with `sat_en` low, the sum is masked to 48 bits.
- R8: In modes 2 and 3 (fractional), overflow is tested as in R4. With `sat_en` high, the result becomes 0x7FFF_FFFF_FFFF for a non-negative sum and 0x8000_0000_0000 for a negative sum.
- R9: `ovf` shows the overflow result of the most recent add or subtract, and keeps its value through all other commands. An overflow sets `pav[dst]`. That flag stays set through later adds and subtracts.
- R10: Command 3 loads `load_data` sign-extended, command 4 loads it zero-extended, and command 5 loads it sign-extended and shifted left by 8. Each of these clears `pav[dst]`.
- R11: Command 6 copies `acc[src]` into `acc[dst]`, and `pav[dst]` takes the value of `pav[src]`.
- R12: Command 7 clears `pav[dst]` and leaves every accumulator unchanged.
- R13: Only `acc[dst]` can change in a cycle. Command 0 changes no accumulator, flag or `ovf`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd | input | 3 | Operation: 0 none, 1 add, 2 subtract, 3/4/5 load signed/unsigned/fractional, 6 copy, 7 clear flag |
| dst | input | 2 | Target accumulator index |
| src | input | 2 | Source accumulator index for copy |
| product | input | 64 | Product to add or subtract |
| load_data | input | 32 | Operand for loads |
| mode | input | 2 | 0 signed integer, 1 unsigned, 2 or 3 fractional |
| sat_en | input | 1 | Saturate on overflow instead of wrapping |
| acc_flat | output | 192 | All accumulators, index i at bits [48i+47:48i] |
| pav | output | 4 | Sticky per-accumulator overflow flags |
| ovf | output | 1 | Overflow result of the last add or subtract |

## Verification
A wrong extension or a wrong overflow test shows on the accumulator output one cycle after the offending add or subtract. The error appears as a wrapped value where a clamp was due, or as a clamp toward the wrong limit. A stray write to an unselected register also shows on the next cycle, because all four registers are compared after every command. A lost or spurious flag shows on `pav` straight away. It can also show later, when a copy carries the wrong flag to another register.

// File: rtl/mac_acc_bank.sv
module mac_acc_bank #(
  parameter int NACC = 4,
  parameter int AW   = 48,
  parameter int PW   = 64,
  parameter int DW   = 32,
  parameter int IW   = $clog2(NACC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2:0]         cmd,
  input  logic [IW-1:0]      dst,
  input  logic [IW-1:0]      src,
  input  logic [PW-1:0]      product,
  input  logic [DW-1:0]      load_data,
  input  logic [1:0]         mode,
  input  logic               sat_en,
  output logic [NACC*AW-1:0] acc_flat,
  output logic [NACC-1:0]    pav,
  output logic               ovf
);
  localparam logic [PW-1:0] UWRAP = PW'(1) << (AW + 5);
  localparam logic [AW-1:0] IMAX  = {{(AW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic [AW-1:0] IMIN  = {{(AW-DW+1){1'b1}}, {(DW-1){1'b0}}};
  localparam logic [AW-1:0] FMAX  = {1'b0, {(AW-1){1'b1}}};
  localparam logic [AW-1:0] FMIN  = {1'b1, {(AW-1){1'b0}}};

  logic [AW-1:0] acc [NACC];
  logic [AW-1:0] cur, sat_val, arith_res;
  logic [PW-1:0] ext, sum;
  logic [PW-AW:0] top_s;
  logic          uns, s_ovf, u_ovf, new_ovf;

  assign cur   = acc[dst];
  assign uns   = (mode == 2'd1);
  assign ext   = uns ? PW'(cur) : {{(PW-AW){cur[AW-1]}}, cur};
  assign sum   = (cmd == 3'd2) ? ext - product : ext + product;
  assign top_s = sum[PW-1:AW-1];
  assign s_ovf = |top_s && !(&top_s);
  assign u_ovf = |sum[PW-1:AW];
  assign new_ovf = uns ? u_ovf : s_ovf;

  always_comb begin
    case (mode)
      2'd0:    sat_val = sum[PW-1] ? IMIN : IMAX;
      2'd1:    sat_val = (sum > UWRAP) ? '0 : '1;
      default: sat_val = sum[PW-1] ? FMIN : FMAX;
    endcase
  end

  assign arith_res = (new_ovf && sat_en) ? sat_val : sum[AW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NACC; i++) acc[i] <= '0;
      pav <= '0;
      ovf <= 1'b0;
    end else begin
      case (cmd)
        3'd1, 3'd2: begin
          acc[dst] <= arith_res;
          ovf      <= new_ovf;
          if (new_ovf) pav[dst] <= 1'b1;
        end
        3'd3: begin
          acc[dst] <= {{(AW-DW){load_data[DW-1]}}, load_data};
          pav[dst] <= 1'b0;
        end
        3'd4: begin
          acc[dst] <= AW'(load_data);
          pav[dst] <= 1'b0;
        end
        3'd5: begin
          acc[dst] <= {{(AW-DW-8){load_data[DW-1]}}, load_data, 8'h00};
          pav[dst] <= 1'b0;
        end
        3'd6: begin
          acc[dst] <= acc[src];
          pav[dst] <= pav[src];
        end
        3'd7: pav[dst] <= 1'b0;
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < NACC; g++) begin : g_out
    assign acc_flat[g*AW +: AW] = acc[g];
  end
endmodule

module mac_acc_bank_chk #(
  parameter int NACC = 4,
  parameter int AW   = 48,
  parameter int PW   = 64,
  parameter int DW   = 32,
  parameter int IW   = $clog2(NACC)
) (
  input logic               clk,
  input logic               rst_n,
  input logic [2:0]         cmd,
  input logic [IW-1:0]      dst,
  input logic [IW-1:0]      src,
  input logic [1:0]         mode,
  input logic               sat_en,
  input logic [NACC*AW-1:0] acc_flat,
  input logic [NACC-1:0]    pav,
  input logic               ovf
);
  function automatic logic [AW-1:0] pick(input logic [NACC*AW-1:0] f, input logic [IW-1:0] i);
    return f[i*AW +: AW];
  endfunction

  logic addsub;
  assign addsub = (cmd == 3'd1) || (cmd == 3'd2);

  assert_int_sat_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (addsub && mode == 2'd0 && sat_en) |=> (!ovf ||
      pick(acc_flat, $past(dst)) == {{(AW-DW+1){1'b0}}, {(DW-1){1'b1}}} ||
      pick(acc_flat, $past(dst)) == {{(AW-DW+1){1'b1}}, {(DW-1){1'b0}}}));

  assert_uns_sat_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (addsub && mode == 2'd1 && sat_en) |=> (!ovf ||
      pick(acc_flat, $past(dst)) == '0 || pick(acc_flat, $past(dst)) == '1));

  assert_frac_sat_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (addsub && mode[1] && sat_en) |=> (!ovf ||
      pick(acc_flat, $past(dst)) == {1'b0, {(AW-1){1'b1}}} ||
      pick(acc_flat, $past(dst)) == {1'b1, {(AW-1){1'b0}}}));

  assert_ovf_sets_pav_R9: assert property (@(posedge clk) disable iff (!rst_n)
    addsub |=> (!ovf || pav[$past(dst)]));

  assert_pav_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (addsub && pav[dst]) |=> pav[$past(dst)]);

  assert_load_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd inside {3'd3, 3'd4, 3'd5}) |=> !pav[$past(dst)]);

  assert_copy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 3'd6) |=> (pick(acc_flat, $past(dst)) == pick($past(acc_flat), $past(src)) &&
                       pav[$past(dst)] == $past(pav[src])));

  assert_clear_keeps_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 3'd7) |=> ($stable(acc_flat) && !pav[$past(dst)]));

  assert_nop_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 3'd0) |=> ($stable(acc_flat) && $stable(pav) && $stable(ovf)));

  for (genvar g = 0; g < NACC; g++) begin : g_iso
    assert_unselected_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (dst != IW'(g)) |=> $stable(acc_flat[g*AW +: AW]));
  end
endmodule

bind mac_acc_bank mac_acc_bank_chk #(.NACC(NACC), .AW(AW), .PW(PW), .DW(DW), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd(cmd), .dst(dst), .src(src), .mode(mode),
  .sat_en(sat_en), .acc_flat(acc_flat), .pav(pav), .ovf(ovf)
);

// File: tb/test_mac_acc_bank.sv
`timescale 1ns/1ps
module test_mac_acc_bank;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [2:0]   cmd = '0;
  logic [1:0]   dst = '0, src = '0;
  logic [63:0]  product = '0;
  logic [31:0]  load_data = '0;
  logic [1:0]   mode = '0;
  logic         sat_en = 1'b0;
  logic [191:0] acc_flat;
  logic [3:0]   pav;
  logic         ovf;

  int checks = 0, errors = 0;
  logic [47:0] e_acc [4];
  logic [3:0]  e_pav;
  logic        e_ovf;
  logic        last_o;

  always #4 clk = ~clk;

  mac_acc_bank i_mac_acc_bank (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .dst(dst), .src(src), .product(product),
    .load_data(load_data), .mode(mode), .sat_en(sat_en),
    .acc_flat(acc_flat), .pav(pav), .ovf(ovf)
  );

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete (actual hung, expected done)");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic compare(input string tag_a, input string tag_f);
    logic bad = 1'b0;
    checks++;
    for (int i = 0; i < 4; i++)
      if (acc_flat[i*48 +: 48] !== e_acc[i]) begin
        bad = 1'b1;
        $display("FAIL %s acc%0d actual %h expected %h", tag_a, i, acc_flat[i*48 +: 48], e_acc[i]);
      end
    if (pav !== e_pav || ovf !== e_ovf) begin
      bad = 1'b1;
      $display("FAIL %s flags actual pav=%b ovf=%b expected pav=%b ovf=%b", tag_f, pav, ovf, e_pav, e_ovf);
    end
    if (bad) errors++;
  endtask

  task automatic model(input logic [2:0] c, input logic [1:0] d, input logic [1:0] s,
                       input logic [63:0] p, input logic [31:0] ld, input logic [1:0] m, input logic sat);
    logic [63:0] x, sm;
    logic [47:0] r;
    logic o;
    case (c)
      3'd1, 3'd2: begin
        x  = (m == 2'd1) ? {16'h0, e_acc[d]} : {{16{e_acc[d][47]}}, e_acc[d]};
        sm = (c == 3'd1) ? x + p : x - p;
        if (m == 2'd1) begin
          o = sm[63:48] != 16'h0;
          r = (o && sat) ? ((sm > 64'h0020_0000_0000_0000) ? 48'h0 : 48'hFFFF_FFFF_FFFF) : sm[47:0];
        end else begin
          o = $signed(sm) != $signed({{16{sm[47]}}, sm[47:0]});
          if (o && sat)
            r = (m == 2'd0) ? (sm[63] ? 48'hFFFF_8000_0000 : 48'h0000_7FFF_FFFF)
                            : (sm[63] ? 48'h8000_0000_0000 : 48'h7FFF_FFFF_FFFF);
          else r = sm[47:0];
        end
        e_acc[d] = r;
        e_ovf = o;
        last_o = o;
        if (o) e_pav[d] = 1'b1;
      end
      3'd3: begin e_acc[d] = {{16{ld[31]}}, ld}; e_pav[d] = 1'b0; end
      3'd4: begin e_acc[d] = {16'h0, ld}; e_pav[d] = 1'b0; end
      3'd5: begin e_acc[d] = {{8{ld[31]}}, ld, 8'h00}; e_pav[d] = 1'b0; end
      3'd6: begin e_acc[d] = e_acc[s]; e_pav[d] = e_pav[s]; end
      3'd7: e_pav[d] = 1'b0;
      default: ;
    endcase
  endtask

  task automatic run(input logic [2:0] c, input logic [1:0] d, input logic [1:0] s,
                     input logic [63:0] p, input logic [31:0] ld, input logic [1:0] m,
                     input logic sat, input string tag_a, input string tag_f);
    cmd = c; dst = d; src = s; product = p; load_data = ld; mode = m; sat_en = sat;
    @(negedge clk);
    model(c, d, s, p, ld, m, sat);
    compare(tag_a, tag_f);
  endtask

  logic [63:0] bases [6];
  logic [63:0] prods [6];

  initial begin
    bases[0] = 64'h0;
    bases[1] = 64'h0000_7FFF_FFFF_FFF0;
    bases[2] = 64'hFFFF_FFFF_FFFF_FFF0;
    bases[3] = 64'h0000_0000_7FFF_FFF0;
    bases[4] = 64'h0000_FFFF_FFFF_FFF0;
    bases[5] = 64'h0000_8000_0000_0010;
    prods[0] = 64'h1;
    prods[1] = 64'h10;
    prods[2] = 64'h20;
    prods[3] = 64'h0010_0000_0000_0000;
    prods[4] = 64'h0040_0000_0000_0000;
    prods[5] = 64'hFFFF_FFFF_FFFF_FFE0;
    for (int i = 0; i < 4; i++) e_acc[i] = '0;
    e_pav = '0; e_ovf = 1'b0; last_o = 1'b0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    compare("R1", "R1");

    run(3'd3, 2'd0, 2'd0, 64'h0, 32'h8000_0000, 2'd0, 1'b0, "R10", "R10");
    run(3'd4, 2'd1, 2'd0, 64'h0, 32'h8000_0000, 2'd0, 1'b0, "R10", "R10");
    run(3'd5, 2'd2, 2'd0, 64'h0, 32'hFFFF_FFFF, 2'd0, 1'b0, "R10", "R10");
    run(3'd5, 2'd3, 2'd0, 64'h0, 32'h7FFF_FFFF, 2'd0, 1'b0, "R10", "R10");
    run(3'd0, 2'd3, 2'd1, 64'h5, 32'h1234, 2'd0, 1'b1, "R13", "R13");

    run(3'd1, 2'd1, 2'd0, 64'h0000_FFFF_0000_0000, 32'h0, 2'd1, 1'b0, "R7", "R9");
    run(3'd6, 2'd2, 2'd1, 64'h0, 32'h0, 2'd0, 1'b0, "R11", "R11");
    run(3'd6, 2'd1, 2'd0, 64'h0, 32'h0, 2'd0, 1'b0, "R11", "R11");
    run(3'd7, 2'd2, 2'd0, 64'h0, 32'h0, 2'd0, 1'b0, "R12", "R12");
    run(3'd1, 2'd3, 2'd0, 64'h0000_7FFF_FFFF_FFFF, 32'h0, 2'd2, 1'b1, "R8", "R9");
    run(3'd2, 2'd3, 2'd0, 64'h0, 32'h0, 2'd2, 1'b0, "R3", "R9");
    run(3'd1, 2'd3, 2'd0, 64'h0, 32'h0, 2'd2, 1'b0, "R2", "R9");

    for (int m = 0; m < 3; m++)
      for (int sat = 0; sat < 2; sat++)
        for (int b = 0; b < 6; b++)
          for (int p = 0; p < 6; p++)
            for (int op = 1; op <= 2; op++) begin
              logic [1:0] d = 2'((b + p + op) % 4);
              string t;
              run(3'd4, d, 2'd0, 64'h0, 32'h0, 2'(m), 1'(sat), "R10", "R10");
              run(3'd1, d, 2'd0, bases[b], 32'h0, 2'(m), 1'b0, "R5", "R9");
              cmd = 3'(op); dst = d; src = 2'd0; product = prods[p]; mode = 2'(m); sat_en = 1'(sat);
              @(negedge clk);
              model(3'(op), d, 2'd0, prods[p], 32'h0, 2'(m), 1'(sat));
              if (!last_o) t = (op == 1) ? "R2" : "R3";
              else if (m == 1) t = sat ? "R6" : "R7";
              else if (sat) t = (m == 0) ? "R4" : "R8";
              else t = "R5";
              compare(t, "R9");
              run(3'd7, d, 2'd0, 64'h0, 32'h0, 2'(m), 1'(sat), "R12", "R12");
            end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule